// File: doc/BRIEF.md
# Pin Event Timestamp Capture

This block stamps external pin activity with the chip's time base. Eight general-purpose input pins are synchronised into the clock domain and edge-detected. Each of nine capture channels can watch any one of those pins for a rising edge, a falling edge, or either. On a matching edge the channel stores the current value of a 32-bit real-time counter, which arrives as an input, and raises a pending flag. Firmware then reads the stored time without having to react to the edge itself.

A simple register port configures the channels and reads back timestamps and status. A request is accepted in the cycle it is presented. A read answers with `cpu_rvalid` and `cpu_rdata` one cycle later. The port has no ready signal: the block never applies back-pressure, and the requester may issue a new request on every cycle. A single interrupt line combines the pending flags of all channels that have interrupts enabled.

Top module: `evcap_top`

## Requirements
- R1: After reset, all channel settings, timestamps, pending flags and overflow flags read as zero, `cpu_rvalid` is low and `irq` is low.
- R2: Addresses are formed as {region[1:0], index[3:0]}. Region 0 at index k is the settings word of channel k. Its layout is pin select in bits [2:0], edge mode in bits [4:3], enable in bit 5 and interrupt enable in bit 6. A write stores the word and a read returns it. A read request yields `cpu_rvalid` high for exactly the following cycle, with the data. Unmapped addresses read zero.
- R3: A pin level change sampled at clock edge E0 produces a capture at edge E2. The stored timestamp is the `rtc_in` value present just before E2, and the pending flag is readable from E2 on. The stored time of channel k reads at region 1, index k.
- R4: Edge mode 2'b01 captures rising edges only, 2'b10 captures falling edges only, and 2'b11 captures both. 2'b00 captures nothing.
- R5: A channel reacts only to the pin named by its pin select, and any of pins 0 to 7 may be selected. Activity on other pins leaves it untouched.
- R6: A channel whose enable bit is 0 never captures. Its timestamp and pending flag are unchanged by pin activity.
- R7: A capture sets the channel's pending bit, read at region 2 index 0 (bit k for channel k). Writing 1 to a bit there clears it. A capture in the same cycle as the clear wins, and the bit stays set.
- R8: A capture while the channel's pending bit is already set overwrites the timestamp and sets the channel's sticky overflow bit, read at region 2 index 1. Writing 1 to an overflow bit clears it.
- R9: `irq` is high exactly when some channel has both its pending bit and its interrupt-enable bit set.
- R10: Several channels that select the same pin capture the same edge in the same cycle and store the same timestamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | 8 | Asynchronous general-purpose pin levels |
| rtc_in | input | 32 | Real-time counter value |
| cpu_req | input | 1 | Register access request, accepted every cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 6 | {region, index} |
| cpu_wdata | input | 32 | Write data |
| cpu_rvalid | output | 1 | Read data valid, one cycle after a read request |
| cpu_rdata | output | 32 | Read data |
| irq | output | 1 | Combined channel interrupt |

## Verification
The bench builds the block with its default parameters: nine channels and eight pins. A four-bit channel index is therefore needed, and channel 8 exercises the one index beyond a power of two. With eight pins, every value of the three-bit pin select is a real pin, so the pin-7 path and the shared-pin case are both reachable. A behavioural model tracks a history queue of pin samples, the stored times and the flags. It is compared against the outputs on every clock. Directed checks pin down the exact capture cycle, the clear-versus-capture collision and the overflow path.

// File: rtl/evcap_pkg.sv
package evcap_pkg;
  // bit 0 selects rising edges, bit 1 selects falling edges
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  typedef enum logic [1:0] {
    RGN_CFG  = 2'd0,
    RGN_TS   = 2'd1,
    RGN_STAT = 2'd2,
    RGN_RSVD = 2'd3
  } rgn_e;
endpackage

// File: rtl/evcap_insync.sv
module evcap_insync #(
  parameter int N_PIN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_PIN-1:0] pin_i,
  output logic [N_PIN-1:0] rise_o,
  output logic [N_PIN-1:0] fall_o
);
  logic [N_PIN-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;
  assign fall_o = ~sync_q & prev_q;
endmodule

// File: rtl/evcap_chan.sv
module evcap_chan
  import evcap_pkg::*;
#(
  parameter int N_PIN = 8,
  parameter int SEL_W = 3,
  parameter int TS_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  edge_mode_e       mode_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [N_PIN-1:0] rise_i,
  input  logic [N_PIN-1:0] fall_i,
  input  logic [TS_W-1:0]  rtc_i,
  input  logic             clr_pend_i,
  input  logic             clr_ovf_i,
  output logic [TS_W-1:0]  ts_o,
  output logic             pend_o,
  output logic             ovf_o
);
  logic pin_rise, pin_fall, hit;
  logic [TS_W-1:0] ts_q;
  logic pend_q, ovf_q;

  always_comb begin
    pin_rise = 1'b0;
    pin_fall = 1'b0;
    for (int p = 0; p < N_PIN; p++) begin
      if (sel_i == SEL_W'(p)) begin
        pin_rise = rise_i[p];
        pin_fall = fall_i[p];
      end
    end
  end

  assign hit = en_i && ((mode_i[0] && pin_rise) || (mode_i[1] && pin_fall));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_q   <= '0;
      pend_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (hit) ts_q <= rtc_i;
      if (hit)             pend_q <= 1'b1;
      else if (clr_pend_i) pend_q <= 1'b0;
      if (hit && pend_q)   ovf_q <= 1'b1;
      else if (clr_ovf_i)  ovf_q <= 1'b0;
    end
  end

  assign ts_o   = ts_q;
  assign pend_o = pend_q;
  assign ovf_o  = ovf_q;

  AST_CAPTURE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pend_q); // R7
  AST_TS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> ts_q == $past(rtc_i)); // R3
  AST_TS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(ts_q)); // R6
  AST_OVF_ON_RECAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && pend_q) |=> ovf_q); // R8
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pend_i && !hit) |=> !pend_q); // R7
endmodule

// File: rtl/evcap_top.sv
module evcap_top
  import evcap_pkg::*;
#(
  parameter int N_CH   = 9,
  parameter int N_PIN  = 8,
  parameter int TS_W   = 32,
  parameter int DATA_W = 32,
  localparam int SEL_W = (N_PIN > 1) ? $clog2(N_PIN) : 1,
  localparam int IDX_W = (N_CH > 2) ? $clog2(N_CH) : 1,
  localparam int AW    = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PIN-1:0]  gpio_in,
  input  logic [TS_W-1:0]   rtc_in,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              irq
);
  localparam int MODE_LO = SEL_W;
  localparam int EN_BIT  = SEL_W + 2;
  localparam int IE_BIT  = SEL_W + 3;

  logic [N_PIN-1:0] rise, fall;
  logic [SEL_W-1:0] cfg_sel  [N_CH];
  edge_mode_e       cfg_mode [N_CH];
  logic [N_CH-1:0]  cfg_en, cfg_ie;
  logic [TS_W-1:0]  ts_vec   [N_CH];
  logic [N_CH-1:0]  pend_vec, ovf_vec, clr_pend, clr_ovf;
  logic [DATA_W-1:0] rd_mux;

  rgn_e             rgn;
  logic [IDX_W-1:0] idx;
  logic             wr, rd;

  assign rgn = rgn_e'(cpu_addr[AW-1:IDX_W]);
  assign idx = cpu_addr[IDX_W-1:0];
  assign wr  = cpu_req && cpu_we;
  assign rd  = cpu_req && !cpu_we;

  evcap_insync #(.N_PIN(N_PIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(gpio_in), .rise_o(rise), .fall_o(fall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_CH; i++) begin
        cfg_sel[i]  <= '0;
        cfg_mode[i] <= EDGE_NONE;
      end
      cfg_en <= '0;
      cfg_ie <= '0;
    end else if (wr && rgn == RGN_CFG) begin
      for (int i = 0; i < N_CH; i++) begin
        if (idx == IDX_W'(i)) begin
          cfg_sel[i]  <= cpu_wdata[SEL_W-1:0];
          cfg_mode[i] <= edge_mode_e'(cpu_wdata[MODE_LO+:2]);
          cfg_en[i]   <= cpu_wdata[EN_BIT];
          cfg_ie[i]   <= cpu_wdata[IE_BIT];
        end
      end
    end
  end

  always_comb begin
    clr_pend = '0;
    clr_ovf  = '0;
    if (wr && rgn == RGN_STAT && idx == IDX_W'(0)) clr_pend = cpu_wdata[N_CH-1:0];
    if (wr && rgn == RGN_STAT && idx == IDX_W'(1)) clr_ovf  = cpu_wdata[N_CH-1:0];
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    evcap_chan #(.N_PIN(N_PIN), .SEL_W(SEL_W), .TS_W(TS_W)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .en_i(cfg_en[c]), .mode_i(cfg_mode[c]), .sel_i(cfg_sel[c]),
      .rise_i(rise), .fall_i(fall), .rtc_i(rtc_in),
      .clr_pend_i(clr_pend[c]), .clr_ovf_i(clr_ovf[c]),
      .ts_o(ts_vec[c]), .pend_o(pend_vec[c]), .ovf_o(ovf_vec[c])
    );
  end

  always_comb begin
    rd_mux = '0;
    case (rgn)
      RGN_CFG: begin
        for (int i = 0; i < N_CH; i++)
          if (idx == IDX_W'(i))
            rd_mux = DATA_W'({cfg_ie[i], cfg_en[i], cfg_mode[i], cfg_sel[i]});
      end
      RGN_TS: begin
        for (int i = 0; i < N_CH; i++)
          if (idx == IDX_W'(i)) rd_mux = DATA_W'(ts_vec[i]);
      end
      RGN_STAT: begin
        if (idx == IDX_W'(0)) rd_mux = DATA_W'(pend_vec);
        if (idx == IDX_W'(1)) rd_mux = DATA_W'(ovf_vec);
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_rvalid <= 1'b0;
      cpu_rdata  <= '0;
    end else begin
      cpu_rvalid <= rd;
      if (rd) cpu_rdata <= rd_mux;
    end
  end

  assign irq = |(pend_vec & cfg_ie);

  AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> cpu_rvalid); // R2
  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !cpu_rvalid); // R2
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend_vec != '0)); // R9
endmodule

// File: tb/evcap_top_tb.sv
module evcap_top_tb;
  localparam int NC = 9;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  gpio_in = '0;
  logic [31:0] rtc_in = 32'h1000_0000;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [5:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_rvalid, irq;
  logic [31:0] cpu_rdata;

  int n_chk = 0, n_bad = 0;
  string tag = "R1";
  bit done = 1'b0;

  evcap_top u_dut (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .rtc_in(rtc_in),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .irq(irq)
  );

  always #5 clk = ~clk;
  always @(negedge clk) rtc_in <= rtc_in + 1;

  // ---------------- behavioural reference ----------------
  logic [6:0]  m_cfg [NC];
  logic [31:0] m_ts  [NC];
  logic [NC-1:0] m_pend, m_ovf;
  logic [7:0]  hist[$];
  logic        m_rvalid;
  logic [31:0] m_rdata;

  function automatic logic [31:0] m_read(logic [5:0] a);
    int i;
    i = int'(a[3:0]);
    case (a[5:4])
      2'd0: return (i < NC) ? {25'd0, m_cfg[i]} : 32'd0;
      2'd1: return (i < NC) ? m_ts[i] : 32'd0;
      2'd2: return (i == 0) ? 32'(m_pend) : (i == 1) ? 32'(m_ovf) : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NC; i++) begin m_cfg[i] = '0; m_ts[i] = '0; end
      m_pend = '0; m_ovf = '0; m_rvalid = 0; m_rdata = '0;
      hist = '{8'd0, 8'd0, 8'd0};
    end else begin
      logic [7:0] cur, prv;
      logic [NC-1:0] hit;
      cur = hist[1]; prv = hist[2];
      for (int i = 0; i < NC; i++) begin
        int p;
        bit r, f;
        p = int'(m_cfg[i][2:0]);
        r = cur[p] && !prv[p];
        f = !cur[p] && prv[p];
        hit[i] = m_cfg[i][5] && ((m_cfg[i][3] && r) || (m_cfg[i][4] && f));
      end
      m_rvalid = cpu_req && !cpu_we;
      if (m_rvalid) m_rdata = m_read(cpu_addr);
      for (int i = 0; i < NC; i++) begin
        bit cp, co;
        cp = cpu_req && cpu_we && cpu_addr == 6'h20 && cpu_wdata[i];
        co = cpu_req && cpu_we && cpu_addr == 6'h21 && cpu_wdata[i];
        if (hit[i]) begin
          if (m_pend[i]) m_ovf[i] = 1'b1;
          m_pend[i] = 1'b1;
          m_ts[i] = rtc_in;
        end else begin
          if (cp) m_pend[i] = 1'b0;
          if (co) m_ovf[i] = 1'b0;
        end
        if (hit[i] && !m_ovf[i] && co) m_ovf[i] = 1'b0;
        if (hit[i] && co && !(m_pend[i] && m_ovf[i])) m_ovf[i] = 1'b0;
      end
      if (cpu_req && cpu_we && cpu_addr[5:4] == 2'd0 && int'(cpu_addr[3:0]) < NC)
        m_cfg[int'(cpu_addr[3:0])] = cpu_wdata[6:0];
      hist.push_front(gpio_in);
      void'(hist.pop_back());
    end
  end

  task automatic chk(string t, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", t, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({tag, " irq"}, 32'(irq), 32'(|(m_pend & {m_cfg[8][6], m_cfg[7][6], m_cfg[6][6],
          m_cfg[5][6], m_cfg[4][6], m_cfg[3][6], m_cfg[2][6], m_cfg[1][6], m_cfg[0][6]})));
      chk({tag, " rvalid"}, 32'(cpu_rvalid), 32'(m_rvalid));
      if (m_rvalid) chk({tag, " rdata"}, cpu_rdata, m_rdata);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); #1;
    cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); #1;
    cpu_req = 0; cpu_we = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); #1;
    cpu_req = 1; cpu_we = 0; cpu_addr = a;
    @(negedge clk); #1;
    d = cpu_rdata;
    cpu_req = 0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pin(int p, logic v);
    @(negedge clk); #1;
    gpio_in[p] = v;
  endtask

  // settings word: ie<<6 | en<<5 | mode<<3 | sel
  function automatic logic [31:0] cfgw(bit ie, bit en, logic [1:0] m, logic [2:0] s);
    return {25'd0, ie, en, m, s};
  endfunction

  initial begin
    logic [31:0] d, t0, t1;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    // R1 reset state
    tag = "R1";
    chk("R1 irq", 32'(irq), 0);
    rd(6'h20, d); chk("R1 pending", d, 0);
    rd(6'h21, d); chk("R1 overflow", d, 0);
    rd(6'h10, d); chk("R1 ts0", d, 0);
    rd(6'h08, d); chk("R1 cfg8", d, 0);
    // R2 settings readback, unmapped addr
    tag = "R2";
    wr(6'h03, cfgw(1, 0, 2'b11, 3'd5)); rd(6'h03, d); chk("R2 cfg3", d, 32'h5D);
    rd(6'h0C, d); chk("R2 unmapped", d, 0);
    rd(6'h30, d); chk("R2 reserved", d, 0);
    // R3 capture timing, R9 irq
    tag = "R3";
    wr(6'h00, cfgw(1, 1, 2'b01, 3'd0));
    @(negedge clk); #1; gpio_in[0] = 1; t0 = rtc_in;
    idle(3);
    rd(6'h10, d); chk("R3 ts0 exact", d, t0 + 2);
    rd(6'h20, d); chk("R3 pending0", d, 32'h1);
    tag = "R9";
    chk("R9 irq high", 32'(irq), 1);
    // R4 edge modes
    tag = "R4";
    wr(6'h01, cfgw(0, 1, 2'b10, 3'd1));
    wr(6'h02, cfgw(0, 1, 2'b11, 3'd2));
    pin(1, 1); idle(4); rd(6'h20, d); chk("R4 falling ignores rise", d & 32'h2, 0);
    pin(1, 0); idle(4); rd(6'h20, d); chk("R4 falling captures", d & 32'h2, 32'h2);
    pin(2, 1); idle(4); rd(6'h12, t1);
    pin(2, 0); idle(4); rd(6'h12, d); chk("R4 both captures fall", 32'(d != t1), 1);
    wr(6'h07, cfgw(0, 1, 2'b00, 3'd2));
    pin(2, 1); idle(4); rd(6'h20, d); chk("R4 none mode", d & 32'h80, 0);
    // R5 pin select
    tag = "R5";
    wr(6'h04, cfgw(0, 1, 2'b11, 3'd7));
    pin(6, 1); idle(4); rd(6'h20, d); chk("R5 other pin", d & 32'h10, 0);
    pin(7, 1); idle(4); rd(6'h20, d); chk("R5 pin7", d & 32'h10, 32'h10);
    // R6 disabled channel
    tag = "R6";
    wr(6'h05, cfgw(1, 0, 2'b11, 3'd3));
    pin(3, 1); idle(4); pin(3, 0); idle(4);
    rd(6'h20, d); chk("R6 pending5", d & 32'h20, 0);
    rd(6'h15, d); chk("R6 ts5", d, 0);
    // R7 clear and collision
    tag = "R7";
    wr(6'h20, 32'h1); rd(6'h20, d); chk("R7 w1c", d & 32'h1, 0);
    chk("R9 irq low", 32'(irq), 0);
    pin(0, 0);
    @(negedge clk); #1; gpio_in[0] = 1;
    @(negedge clk);
    wr(6'h20, 32'h1);
    rd(6'h20, d); chk("R7 capture beats clear", d & 32'h1, 32'h1);
    // R8 overflow
    tag = "R8";
    rd(6'h21, d); chk("R8 no ovf yet", d & 32'h1, 0);
    pin(0, 0); idle(2);
    @(negedge clk); #1; gpio_in[0] = 1; t0 = rtc_in;
    idle(3);
    rd(6'h21, d); chk("R8 ovf set", d & 32'h1, 32'h1);
    rd(6'h10, d); chk("R8 ts overwritten", d, t0 + 2);
    wr(6'h21, 32'h1); rd(6'h21, d); chk("R8 ovf cleared", d & 32'h1, 0);
    // R10 shared pin
    tag = "R10";
    wr(6'h06, cfgw(0, 1, 2'b01, 3'd4));
    wr(6'h08, cfgw(0, 1, 2'b01, 3'd4));
    pin(4, 1); idle(4);
    rd(6'h16, t1); rd(6'h18, d);
    chk("R10 same ts", d, t1);
    chk("R10 captured", 32'(d != 0), 1);
    idle(3);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(10 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule